// File: doc/BRIEF.md
# Page-Mode Byte Memory Strobe Controller

This block sits between a simple synchronous request port and a byte-wide parallel nonvolatile memory with active-low strobes. The memory is organised as rows of eight bytes. The upper twelve address bits name a row, and the lower three bits pick a byte inside that row. A host issues single-byte read or write requests through a valid/ready handshake. The controller turns each request into a chip-enable, output-enable and write-enable sequence. Every timing interval is counted in clock cycles.

Once a row is open, chip enable stays low. Further requests to the same row are served as page accesses that change only the column bits. A request to another row closes the open row: chip enable rises and is held high for a precharge interval before the new access starts. A row that sees no request for an idle timeout is closed in the same way. Each written byte gets its own write-enable pulse. The host drives the byte bus only during that pulse, and output enable stays high while it does so.

Top module: `pgm_ctrl`

## Requirements
- R1: While reset is held and right after it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dout_en` and `rd_valid` are 0, and `req_ready` is 1.
- R2: A read accepted with no precharge pending holds `mem_oe_n` low for `T_ACC` cycles. `rd_valid` is then high for one cycle, `T_ACC+1` cycles after the accepting edge. `rd_data` carries the byte that was on `mem_din` in the last cycle of that window.
- R3: A write holds `mem_we_n` low for exactly `T_WP` cycles. During those cycles `mem_dout_en` is 1, `mem_dout` equals the request data and `mem_addr` equals the request address. `mem_dout_en` is never 1 outside such a pulse.
- R4: A request whose row (address bits 14..3) equals the open row is served without raising `mem_ce_n`. Only the column bits 2..0 of `mem_addr` may change.
- R5: A request to a different row raises `mem_ce_n` for `T_PRE` cycles before the next falling edge. For a read, the result is therefore due `T_PRE+T_ACC+1` cycles after acceptance.
- R6: With a row open and no request, `mem_ce_n` rises `T_IDLE` cycles after the open state was entered. `req_ready` returns after the following `T_PRE` precharge cycles.
- R7: `req_ready` is 1 only when the controller is idle or has a row open. It is 0 during the access, write and precharge phases.
- R8: `mem_oe_n` is never low while `mem_we_n` is low or `mem_dout_en` is 1.
- R9: N written bytes produce exactly N falling edges of `mem_we_n`, page-mode writes included.
- R10: While `mem_oe_n` stays low, `mem_addr` does not change. A new column is presented only after the current byte has been delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address: row in 14..3, column in 2..0 |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse, `rd_data` valid |
| rd_data | output | 8 | Byte returned by a read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dout | output | 8 | Byte driven toward the memory |
| mem_dout_en | output | 1 | Host drives the byte bus when 1 |
| mem_din | input | 8 | Byte returned from the memory |

## Verification
Latency is measured in falling clock edges after the rising edge that accepts a request:
- A page or idle read delivers at edge `T_ACC+1`, and a row-change read at `T_PRE+T_ACC+1`.
- A write pulse is visible from edge 1, or from edge `T_PRE+1` after a row change, and lasts `T_WP` edges.
- Chip enable rises `T_IDLE` edges after the last result.

Each directed task waits exactly that many falling edges and samples there. A monitor counts chip-enable and write-enable falling edges, so the counts prove that page accesses never toggle chip enable.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_OPEN,
    ST_PRECH
  } pgm_state_t;

  // A phase lasting n cycles is loaded as n-1: the counter exits on zero.
  function automatic int phase_load(input int n_cycles);
    return (n_cycles > 0) ? n_cycles - 1 : 0;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pgm_downcnt.sv
module pgm_downcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pgm_rowtrack.sv
module pgm_rowtrack #(
  parameter int ADDR_W = 15,
  parameter int COL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr,
  output logic              same_row
);
  localparam int ROW_W = ADDR_W - COL_W;

  logic [ROW_W-1:0] open_row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       open_row_q <= '0;
    else if (capture) open_row_q <= addr[ADDR_W-1:COL_W];
  end

  assign same_row = (addr[ADDR_W-1:COL_W] == open_row_q);
endmodule

// File: rtl/pgm_ctrl.sv
module pgm_ctrl
  import pgm_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int COL_W  = 3,
  parameter int T_ACC  = 3,
  parameter int T_PRE  = 2,
  parameter int T_WP   = 2,
  parameter int T_IDLE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din
);
  localparam int PH_MAX = max3(T_ACC, T_PRE, T_WP);
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int ID_W   = $clog2(T_IDLE + 1);
  localparam logic [PH_W-1:0] LD_ACC = PH_W'(phase_load(T_ACC));
  localparam logic [PH_W-1:0] LD_PRE = PH_W'(phase_load(T_PRE));
  localparam logic [PH_W-1:0] LD_WP  = PH_W'(phase_load(T_WP));
  localparam logic [ID_W-1:0] LD_IDL = ID_W'(phase_load(T_IDLE));

  pgm_state_t state_q, state_d;
  logic              pend_write_q, pend_go_q, pend_go_d;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_wdata_q;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  // Named internal events, observed by the bound checker.
  logic ev_accept, ev_row_hit, ev_row_miss;
  logic ev_phase_done, ev_idle_expire;
  logic ph_load, id_load, same_row;
  logic [PH_W-1:0] ph_val;

  assign req_ready     = (state_q == ST_IDLE) || (state_q == ST_OPEN);
  assign ev_accept     = req_valid && req_ready;
  assign ev_row_hit    = ev_accept && (state_q == ST_OPEN) && same_row;
  assign ev_row_miss   = ev_accept && (state_q == ST_OPEN) && !same_row;
  assign id_load       = (state_q != ST_OPEN) || ev_accept;

  pgm_downcnt #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val),
    .zero(ev_phase_done)
  );

  pgm_downcnt #(.W(ID_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .load(id_load), .load_val(LD_IDL),
    .zero(ev_idle_expire)
  );

  pgm_rowtrack #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_row (
    .clk(clk), .rst_n(rst_n), .capture(ev_accept), .addr(req_addr),
    .same_row(same_row)
  );

  always_comb begin
    state_d   = state_q;
    pend_go_d = pend_go_q;
    ph_load   = 1'b0;
    ph_val    = LD_ACC;
    unique case (state_q)
      ST_IDLE: if (ev_accept) begin
        state_d = req_write ? ST_WRITE : ST_READ;
        ph_load = 1'b1;
        ph_val  = req_write ? LD_WP : LD_ACC;
      end
      ST_READ, ST_WRITE: if (ev_phase_done) state_d = ST_OPEN;
      ST_OPEN: begin
        if (ev_row_hit) begin
          state_d = req_write ? ST_WRITE : ST_READ;
          ph_load = 1'b1;
          ph_val  = req_write ? LD_WP : LD_ACC;
        end else if (ev_row_miss || ev_idle_expire) begin
          state_d   = ST_PRECH;
          pend_go_d = ev_row_miss;
          ph_load   = 1'b1;
          ph_val    = LD_PRE;
        end
      end
      ST_PRECH: if (ev_phase_done) begin
        if (pend_go_q) begin
          state_d = pend_write_q ? ST_WRITE : ST_READ;
          ph_load = 1'b1;
          ph_val  = pend_write_q ? LD_WP : LD_ACC;
        end else begin
          state_d = ST_IDLE;
        end
        pend_go_d = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      pend_go_q    <= 1'b0;
      pend_write_q <= 1'b0;
      pend_addr_q  <= '0;
      pend_wdata_q <= '0;
      rd_valid_q   <= 1'b0;
      rd_data_q    <= '0;
    end else begin
      state_q    <= state_d;
      pend_go_q  <= pend_go_d;
      rd_valid_q <= (state_q == ST_READ) && ev_phase_done;
      if ((state_q == ST_READ) && ev_phase_done) rd_data_q <= mem_din;
      if (ev_accept) begin
        pend_write_q <= req_write;
        pend_addr_q  <= req_addr;
        pend_wdata_q <= req_wdata;
      end
    end
  end

  assign mem_ce_n    = !((state_q == ST_READ) || (state_q == ST_WRITE) ||
                         (state_q == ST_OPEN));
  assign mem_oe_n    = (state_q != ST_READ);
  assign mem_we_n    = (state_q != ST_WRITE);
  assign mem_dout_en = (state_q == ST_WRITE);
  assign mem_addr    = pend_addr_q;
  assign mem_dout    = pend_wdata_q;
  assign rd_valid    = rd_valid_q;
  assign rd_data     = rd_data_q;
endmodule

// File: rtl/pgm_ctrl_checker.sv
module pgm_ctrl_checker #(
  parameter int ADDR_W = 15,
  parameter int COL_W  = 3,
  parameter int T_PRE  = 2,
  parameter int T_WP   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dout_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ev_row_hit
);
  int we_run, ce_run;
  logic seen_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run  <= 0;
      ce_run  <= 0;
      seen_ce <= 1'b0;
    end else begin
      we_run <= mem_we_n ? 0 : we_run + 1;
      ce_run <= mem_ce_n ? ce_run + 1 : 0;
      if (!mem_ce_n) seen_ce <= 1'b1;
    end
  end

  assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == T_WP));

  assert_dout_in_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> (!mem_we_n && !mem_ce_n));

  assert_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ce_n) && seen_ce) |-> (ce_run >= T_PRE));

  assert_no_fight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && (!mem_we_n || mem_dout_en)));

  assert_col_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

  assert_hit_keeps_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_row_hit |=> (!mem_ce_n && $stable(mem_addr[ADDR_W-1:COL_W])));

  assert_rdv_after_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (mem_oe_n && $past(!mem_oe_n)));

  assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_oe_n && mem_we_n));
endmodule

bind pgm_ctrl pgm_ctrl_checker #(
  .ADDR_W(ADDR_W), .COL_W(COL_W), .T_PRE(T_PRE), .T_WP(T_WP)
) u_pgm_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_dout_en(mem_dout_en), .mem_addr(mem_addr), .ev_row_hit(ev_row_hit)
);

// File: tb/pgm_ctrl_bench.sv
module pgm_ctrl_bench;
  localparam int T_ACC  = 3;
  localparam int T_PRE  = 2;
  localparam int T_WP   = 2;
  localparam int T_IDLE = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_write, rd_valid;
  logic [14:0] req_addr, mem_addr;
  logic [7:0]  req_wdata, rd_data, mem_dout, mem_din;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;

  pgm_ctrl #(.T_ACC(T_ACC), .T_PRE(T_PRE), .T_WP(T_WP), .T_IDLE(T_IDLE))
  u_pgm_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] model [int];
  logic [7:0] expect_mem [int];

  function automatic logic [7:0] peek(input int a);
    return model.exists(a) ? model[a] : 8'h00;
  endfunction

  always_comb mem_din = (!mem_ce_n && !mem_oe_n) ? peek(int'(mem_addr)) : 8'h00;

  // Memory model and bus monitor, all on the falling edge.
  int ce_falls = 0, we_falls = 0, fight_cnt = 0, col_move_cnt = 0;
  logic prev_ce = 1'b1, prev_we = 1'b1, prev_oe = 1'b1;
  logic [14:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && !mem_we_n && mem_dout_en) model[int'(mem_addr)] = mem_dout;
      if (prev_ce && !mem_ce_n) ce_falls++;
      if (prev_we && !mem_we_n) we_falls++;
      if (!mem_oe_n && (!mem_we_n || mem_dout_en)) fight_cnt++;
      if (!prev_oe && !mem_oe_n && (prev_addr != mem_addr)) col_move_cnt++;
    end
    prev_ce = mem_ce_n; prev_we = mem_we_n; prev_oe = mem_oe_n; prev_addr = mem_addr;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // Present a request at a falling edge, return at the falling edge right
  // after the accepting rising edge (edge 1).
  task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en && !rd_valid,
          "R1", "strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && mem_ce_n && !mem_dout_en, "R1", "ready after reset",
          req_ready, 1);
  endtask

  task automatic t_write(input logic [14:0] a, input logic [7:0] d, input bit miss);
    issue(1'b1, a, d);
    if (miss) begin
      check(!req_ready, "R7", "ready low in precharge", req_ready, 0);
      check(mem_ce_n, "R5", "ce high in precharge", mem_ce_n, 1);
      repeat (T_PRE) @(negedge clk);
    end
    check(!mem_we_n && mem_dout_en && mem_oe_n, "R3", "write pulse strobes",
          {mem_we_n, mem_dout_en, mem_oe_n}, 3);
    check(mem_dout == d && mem_addr == a, "R3", "write bus data", mem_dout, d);
    repeat (T_WP) @(negedge clk);
    check(mem_we_n && !mem_dout_en && !mem_ce_n, "R3", "pulse width ended",
          mem_we_n, 1);
    expect_mem[int'(a)] = d;
  endtask

  task automatic t_read(input logic [14:0] a, input bit miss);
    int lat;
    int exp_lat;
    logic [7:0] exp;
    exp = expect_mem.exists(int'(a)) ? expect_mem[int'(a)] : 8'h00;
    exp_lat = T_ACC + 1 + (miss ? T_PRE : 0);
    issue(1'b0, a, 8'h00);
    lat = 1;
    if (miss) check(!req_ready && mem_ce_n, "R7", "busy during row change",
                    req_ready, 0);
    while (!rd_valid && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    check(lat == exp_lat, miss ? "R5" : "R2", "read latency", lat, exp_lat);
    check(rd_data == exp, "R2", "read byte", rd_data, exp);
  endtask

  task automatic t_idle_close();
    int n = 0;
    while (!mem_ce_n && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == T_IDLE, "R6", "idle timeout", n, T_IDLE);
    check(!req_ready, "R6", "ready low during close precharge", req_ready, 0);
    repeat (T_PRE) @(negedge clk);
    check(req_ready && mem_ce_n, "R6", "idle after precharge", req_ready, 1);
  endtask

  initial begin
    t_reset();
    t_write(15'h0123, 8'hA5, 1'b0);
    check(ce_falls == 1, "R4", "first access ce fall", ce_falls, 1);
    t_write(15'h0124, 8'h3C, 1'b0);
    t_write(15'h0120, 8'h99, 1'b0);
    check(ce_falls == 1, "R4", "page writes keep ce low", ce_falls, 1);
    check(we_falls == 3, "R9", "one pulse per byte", we_falls, 3);
    t_read(15'h0123, 1'b0);
    t_read(15'h0120, 1'b0);
    check(ce_falls == 1, "R4", "page reads keep ce low", ce_falls, 1);
    model[32'h7FF8] = 8'h5A;
    expect_mem[32'h7FF8] = 8'h5A;
    t_read(15'h7FF8, 1'b1);
    check(ce_falls == 2, "R5", "row change new ce fall", ce_falls, 2);
    t_idle_close();
    t_read(15'h0124, 1'b0);
    check(ce_falls == 3, "R2", "read from idle ce fall", ce_falls, 3);
    t_write(15'h4001, 8'h77, 1'b1);
    t_read(15'h4001, 1'b0);
    check(we_falls == 4, "R9", "total write pulses", we_falls, 4);
    check(fight_cnt == 0, "R8", "bus contention cycles", fight_cnt, 0);
    check(col_move_cnt == 0, "R10", "address moved under oe", col_move_cnt, 0);
    finish_run();
  end
endmodule